// File: doc/BRIEF.md
# Post-Calibration Memory Traffic Generator

This block drives a fixed burst of test traffic into a memory controller's local request port once the controller reports that its physical layer has finished calibrating. It stays quiet until the init-done input is seen high. It then issues sixteen writes to a run of addresses, followed by sixteen reads of the same addresses in the same order. At the end it reports whether every returned word matched.

The addresses advance by a fixed stride that bumps the column, row and bank fields together, so the run touches several banks and rows. Each write word is a scrambled function of its own address, produced by a 32-bit LFSR. When a read returns, the checker regenerates the word from the address it expects next, so no copy of the written data is kept. Read data must come back in request order.

Top module: `mem_traffic_gen`

## Requirements
- R1: While init-done has not been sampled high since reset, req_valid stays low. req_valid goes high in the cycle after the first clock edge at which init_done is high. Later changes of init_done have no effect.
- R2: Once req_valid is high, req_valid, req_write, req_addr and req_wdata hold their values until a clock edge at which req_ready is also high. A transfer counts only at such a handshake.
- R3: Exactly 16 write handshakes (req_write=1) take place first, then exactly 16 read handshakes (req_write=0), and after the last read handshake req_valid stays low.
- R4: The address of the k-th write and of the k-th read (k from 0) is (k × 1048833) mod 2^23. The address is laid out as bank[22:20], row[19:8] and column[7:0], and the stride adds one to each of the three fields.
- R5: The write data for address a is built as follows. Start from the seed s = {9'b0, a} XOR 32'hC3A55A5A. Apply four Galois steps, each computing s = (s >> 1) XOR (s[0] ? 32'h80200003 : 0). The result is the write data.
- R6: rd_data is compared only in cycles where rd_valid is high. The n-th returned word is compared against the R5 value for the n-th read address. test_fail rises in the cycle after the first mismatching word is taken, and it stays high until reset.
- R7: test_done rises in the cycle after the 16th valid read word is taken, and it stays high until reset. rd_valid pulses after that point change neither test_fail nor test_done.
- R8: During reset, req_valid, test_done and test_fail are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| init_done | input | 1 | Controller reports calibration complete |
| req_ready | input | 1 | Controller accepts the current request |
| req_valid | output | 1 | Request present |
| req_write | output | 1 | 1 = write request, 0 = read request |
| req_addr | output | 23 | Request address {bank, row, column} |
| req_wdata | output | 32 | Write data |
| rd_valid | input | 1 | Read data word present |
| rd_data | input | 32 | Read data word |
| test_done | output | 1 | All 16 read words checked |
| test_fail | output | 1 | At least one read word mismatched |

## Verification
Five scenarios are run. They combine three controller behaviours: always ready with immediate returns, ready every third cycle with returns on alternate cycles, and an irregular arithmetic ready pattern. Injected corruption is either absent, in the first returned word, or in the last returned word.

The stall-heavy patterns show whether requests are held and counted only on handshakes. The ordering checks tell a write-then-read sequence apart from interleaved traffic. Corrupting the first word and corrupting the last word tell a sticky, correctly timed fail flag apart from one that is cleared or checked against the wrong address. A clean run followed by bad words after done shows whether late read data is ignored.

// File: rtl/mtg_pkg.sv
// Shared types and the LFSR step used by the traffic generator.
package mtg_pkg;
    typedef enum logic [1:0] {PH_IDLE, PH_WRITE, PH_READ, PH_HOLD} phase_t;

    localparam int          LFSR_W    = 32;
    localparam logic [31:0] LFSR_MASK = 32'h8020_0003;

    // One right-shifting Galois step of the maximal-length 32-bit LFSR.
    function automatic logic [LFSR_W-1:0] lfsr_advance(input logic [LFSR_W-1:0] s);
        lfsr_advance = (s >> 1) ^ (s[0] ? LFSR_MASK : '0);
    endfunction
endpackage

// File: rtl/mtg_pattern.sv
// Address-to-data scrambler. Combinational.
// Seeds the LFSR with the address XOR a constant, then steps it WARM_STEPS
// times. Each further 32-bit data lane takes one extra step.
// Assumes ADDR_W < 32, so a constant with bit 31 set keeps the seed nonzero,
// and assumes DATA_W is a multiple of 32.
module mtg_pattern
    import mtg_pkg::*;
#(
    parameter int          ADDR_W     = 23,
    parameter int          DATA_W     = 32,
    parameter int          WARM_STEPS = 4,
    parameter logic [31:0] SEED_XOR   = 32'hC3A5_5A5A
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [DATA_W-1:0] data
);
    localparam int LANES = DATA_W / LFSR_W;
    localparam int CHAIN = WARM_STEPS + LANES - 1;

    logic [LFSR_W-1:0] seed;
    logic [LFSR_W-1:0] stage [CHAIN];

    // Seed formation: zero-extend the address, then mix in the constant.
    always_comb seed = LFSR_W'(addr) ^ SEED_XOR;

    // A nonzero seed keeps the LFSR out of its lock-up state (R5).
    always_comb a_r5_seed_nonzero: assert (seed != '0);

    for (genvar i = 0; i < CHAIN; i++) begin : g_step
        if (i == 0) begin : g_first
            assign stage[i] = lfsr_advance(seed);
        end else begin : g_next
            assign stage[i] = lfsr_advance(stage[i-1]);
        end
    end

    for (genvar j = 0; j < LANES; j++) begin : g_lane
        assign data[j*LFSR_W +: LFSR_W] = stage[WARM_STEPS-1+j];
    end
endmodule

// File: rtl/mtg_seq.sv
// Request sequencer.
// Waits for init_done, issues NUM_XFER writes and then NUM_XFER reads to
// addresses BASE, BASE+STEP, and so on, and then idles until reset.
// Assumes the controller accepts a request on any edge where req_ready is high.
module mtg_seq
    import mtg_pkg::*;
#(
    parameter int                ADDR_W    = 23,
    parameter int                NUM_XFER  = 16,
    parameter logic [ADDR_W-1:0] BASE_ADDR = '0,
    parameter logic [ADDR_W-1:0] ADDR_STEP = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              init_done,
    input  logic              req_ready,
    output logic              req_valid,
    output logic              req_write,
    output logic [ADDR_W-1:0] req_addr
);
    localparam int CNT_W = $clog2(NUM_XFER + 1);

    phase_t            phase;
    logic [CNT_W-1:0]  idx;
    logic [ADDR_W-1:0] addr_q;
    logic              fire;
    logic              last;

    assign fire      = req_valid && req_ready;
    assign last      = (idx == CNT_W'(NUM_XFER - 1));
    assign req_valid = (phase == PH_WRITE) || (phase == PH_READ);
    assign req_write = (phase == PH_WRITE);
    assign req_addr  = addr_q;

    // Phase, transfer count and address advance on each handshake.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase  <= PH_IDLE;
            idx    <= '0;
            addr_q <= BASE_ADDR;
        end else begin
            case (phase)
                PH_IDLE:  if (init_done) phase <= PH_WRITE;
                PH_WRITE: if (fire) begin
                    if (last) begin
                        phase  <= PH_READ;
                        idx    <= '0;
                        addr_q <= BASE_ADDR;
                    end else begin
                        idx    <= idx + 1'b1;
                        addr_q <= addr_q + ADDR_STEP;
                    end
                end
                PH_READ:  if (fire) begin
                    if (last) begin
                        phase <= PH_HOLD;
                    end else begin
                        idx    <= idx + 1'b1;
                        addr_q <= addr_q + ADDR_STEP;
                    end
                end
                default:  phase <= PH_HOLD;
            endcase
        end
    end

    // R1: traffic starts only after init_done has been sampled high.
    a_r1_start_after_init: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(req_valid) |-> $past(init_done));

    // R2: a stalled request keeps its contents.
    a_r2_hold_stalled: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !req_ready |=> req_valid && $stable(req_write) && $stable(req_addr));

    // R3: no write ever follows a read.
    a_r3_write_before_read: assert property (@(posedge clk) disable iff (!rst_n)
        $past(req_valid && !req_write) |-> !(req_valid && req_write));

    // R4: within a phase, each accepted request moves the address by one stride.
    a_r4_addr_stride: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && $past(req_valid && req_ready) && (req_write == $past(req_write))
        |-> req_addr == $past(req_addr) + ADDR_STEP);
endmodule

// File: rtl/mtg_checker.sv
// Read-data checker.
// Takes read words in order, tracks the address it expects next and compares
// each word against the pattern generated for that address (supplied on
// exp_data). Raises a sticky fail flag and a done flag after NUM_XFER words.
// Assumes read data returns in request order.
module mtg_checker #(
    parameter int                ADDR_W    = 23,
    parameter int                DATA_W    = 32,
    parameter int                NUM_XFER  = 16,
    parameter logic [ADDR_W-1:0] BASE_ADDR = '0,
    parameter logic [ADDR_W-1:0] ADDR_STEP = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_valid,
    input  logic [DATA_W-1:0] rd_data,
    input  logic [DATA_W-1:0] exp_data,
    output logic [ADDR_W-1:0] exp_addr,
    output logic              test_done,
    output logic              test_fail
);
    localparam int CNT_W = $clog2(NUM_XFER + 1);

    logic [CNT_W-1:0] cnt;
    logic             take;

    assign take = rd_valid && !test_done;

    // Compare each accepted word and step to the next expected address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt       <= '0;
            exp_addr  <= BASE_ADDR;
            test_done <= 1'b0;
            test_fail <= 1'b0;
        end else if (take) begin
            if (rd_data != exp_data) test_fail <= 1'b1;
            if (cnt == CNT_W'(NUM_XFER - 1)) begin
                test_done <= 1'b1;
            end else begin
                cnt      <= cnt + 1'b1;
                exp_addr <= exp_addr + ADDR_STEP;
            end
        end
    end

    // R6: the fail flag never clears before reset.
    a_r6_fail_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        test_fail |=> test_fail);

    // R7: the done flag never clears before reset.
    a_r7_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        test_done |=> test_done);

    // R7: read words arriving after done leave the fail flag alone.
    a_r7_ignore_late: assert property (@(posedge clk) disable iff (!rst_n)
        test_done && rd_valid |=> $stable(test_fail));

    // R6: with no read word present, the fail flag cannot rise.
    a_r6_only_on_valid: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_valid |=> $stable(test_fail));
endmodule

// File: rtl/mem_traffic_gen.sv
// Post-calibration traffic generator, top level.
// Ties the sequencer, one pattern generator for write data, one pattern
// generator for expected read data, and the read checker together.
// Address layout: {bank, row, column}. The stride adds one to every field.
module mem_traffic_gen #(
    parameter int COL_W      = 8,
    parameter int ROW_W      = 12,
    parameter int BANK_W     = 3,
    parameter int DATA_W     = 32,
    parameter int NUM_XFER   = 16,
    parameter int WARM_STEPS = 4,
    parameter int BASE_ADDR  = 0
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            init_done,
    input  logic                            req_ready,
    output logic                            req_valid,
    output logic                            req_write,
    output logic [COL_W+ROW_W+BANK_W-1:0]   req_addr,
    output logic [DATA_W-1:0]               req_wdata,
    input  logic                            rd_valid,
    input  logic [DATA_W-1:0]               rd_data,
    output logic                            test_done,
    output logic                            test_fail
);
    localparam int                ADDR_W = COL_W + ROW_W + BANK_W;
    localparam logic [ADDR_W-1:0] STEP   = ADDR_W'(1)
                                         + (ADDR_W'(1) << COL_W)
                                         + (ADDR_W'(1) << (COL_W + ROW_W));
    localparam logic [ADDR_W-1:0] BASE   = ADDR_W'(BASE_ADDR);

    logic [ADDR_W-1:0] chk_addr;
    logic [DATA_W-1:0] chk_data;

    mtg_seq #(
        .ADDR_W(ADDR_W), .NUM_XFER(NUM_XFER), .BASE_ADDR(BASE), .ADDR_STEP(STEP)
    ) u_seq (
        .clk(clk), .rst_n(rst_n), .init_done(init_done), .req_ready(req_ready),
        .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr)
    );

    mtg_pattern #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .WARM_STEPS(WARM_STEPS)
    ) u_wr_pat (
        .addr(req_addr), .data(req_wdata)
    );

    mtg_pattern #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .WARM_STEPS(WARM_STEPS)
    ) u_rd_pat (
        .addr(chk_addr), .data(chk_data)
    );

    mtg_checker #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_XFER(NUM_XFER),
        .BASE_ADDR(BASE), .ADDR_STEP(STEP)
    ) u_chk (
        .clk(clk), .rst_n(rst_n), .rd_valid(rd_valid), .rd_data(rd_data),
        .exp_data(chk_data), .exp_addr(chk_addr),
        .test_done(test_done), .test_fail(test_fail)
    );

    // R8: the flags are low while reset is applied.
    a_r8_reset_quiet: assert property (@(posedge clk)
        $past(!rst_n) |-> !req_valid && !test_done && !test_fail);
endmodule

// File: tb/mem_traffic_gen_test.sv
module mem_traffic_gen_test;
    localparam int  CLK_PERIOD = 10;
    localparam int  N          = 16;
    localparam longint STEP    = 1048833;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        init_done;
    logic        req_ready;
    logic        req_valid;
    logic        req_write;
    logic [22:0] req_addr;
    logic [31:0] req_wdata;
    logic        rd_valid;
    logic [31:0] rd_data;
    logic        test_done;
    logic        test_fail;

    int n_tests = 0;
    int n_fail  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mem_traffic_gen uut (
        .clk(clk), .rst_n(rst_n), .init_done(init_done), .req_ready(req_ready),
        .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
        .req_wdata(req_wdata), .rd_valid(rd_valid), .rd_data(rd_data),
        .test_done(test_done), .test_fail(test_fail)
    );

    // Expected address of the k-th transfer, computed arithmetically (R4).
    function automatic logic [22:0] exp_addr(input int k);
        exp_addr = 23'((longint'(k) * STEP) % (64'd1 << 23));
    endfunction

    // Expected write data for an address (R5).
    function automatic logic [31:0] exp_data(input logic [22:0] a);
        logic [31:0] s;
        s = {9'b0, a} ^ 32'hC3A5_5A5A;
        for (int i = 0; i < 4; i++) s = s[0] ? ((s >> 1) ^ 32'h8020_0003) : (s >> 1);
        exp_data = s;
    endfunction

    function automatic bit ready_pat(input int mode, input int c);
        case (mode)
            1:       ready_pat = (c % 3) == 2;
            2:       ready_pat = ((c * 7 + 3) % 5) < 2;
            default: ready_pat = 1'b1;
        endcase
    endfunction

    function automatic bit ret_pat(input int mode, input int c);
        case (mode)
            1:       ret_pat = (c % 2) == 0;
            2:       ret_pat = (c % 4) != 1;
            default: ret_pat = 1'b1;
        endcase
    endfunction

    task automatic check(input string req, input bit ok, input longint act, input longint exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic run(input int mode, input int corrupt);
        logic [31:0] mem [N];
        int wcnt, rcnt, rets, prev_rcnt, tail;
        int quiet_err, hold_err, order_err, addr_err, data_err, done_err, fail_err;
        bit bad_seen, hold_pend, h_wr, rdy;
        logic [22:0] h_addr;
        logic [31:0] h_data;

        rst_n = 1'b0; init_done = 1'b0; req_ready = 1'b0; rd_valid = 1'b0; rd_data = '0;
        repeat (3) @(negedge clk);
        check("R8 reset state", !req_valid && !test_done && !test_fail,
              {req_valid, test_done, test_fail}, 0);
        rst_n = 1'b1;
        quiet_err = 0;
        repeat (20) begin
            @(negedge clk);
            if (req_valid) quiet_err++;
        end
        check("R1 quiet before init", quiet_err == 0, quiet_err, 0);
        init_done = 1'b1;
        @(negedge clk);
        check("R1 start after init", req_valid && req_write, {req_valid, req_write}, 3);

        wcnt = 0; rcnt = 0; rets = 0; tail = 0; bad_seen = 0; hold_pend = 0;
        hold_err = 0; order_err = 0; addr_err = 0; data_err = 0; done_err = 0; fail_err = 0;
        h_wr = 0; h_addr = '0; h_data = '0;
        for (int c = 0; c < 3000; c++) begin
            if (c > 0) @(negedge clk);
            if (mode == 2 && c == 10) init_done = 1'b0;
            prev_rcnt = rcnt;
            if (test_done !== (rets == N)) done_err++;
            if (test_fail !== bad_seen) fail_err++;
            if (hold_pend && (!req_valid || req_write != h_wr || req_addr != h_addr ||
                              req_wdata != h_data)) hold_err++;
            if (req_valid && rcnt >= N) order_err++;
            rdy = ready_pat(mode, c);
            req_ready = rdy;
            hold_pend = req_valid && !rdy;
            h_wr = req_write; h_addr = req_addr; h_data = req_wdata;
            if (req_valid && rdy) begin
                if (req_write) begin
                    if (rcnt != 0 || wcnt >= N) order_err++;
                    else begin
                        if (req_addr != exp_addr(wcnt)) addr_err++;
                        if (req_wdata != exp_data(exp_addr(wcnt))) data_err++;
                        mem[wcnt] = req_wdata;
                    end
                    wcnt++;
                end else begin
                    if (wcnt != N || rcnt >= N) order_err++;
                    else if (req_addr != exp_addr(rcnt)) addr_err++;
                    rcnt++;
                end
            end
            if (rets < prev_rcnt && rets < N && ret_pat(mode, c)) begin
                rd_valid = 1'b1;
                rd_data  = mem[rets] ^ ((rets == corrupt) ? 32'h0000_0010 : 32'h0);
                if (rets == corrupt) bad_seen = 1'b1;
                rets++;
            end else begin
                rd_valid = 1'b0;
                rd_data  = 32'hDEAD_BEEF;
            end
            if (rets == N) tail++;
            if (tail > 4) break;
        end
        rd_valid = 1'b0;

        check("R2 stalled request held", hold_err == 0, hold_err, 0);
        check("R3 write count", wcnt == N, wcnt, N);
        check("R3 read count", rcnt == N, rcnt, N);
        check("R3 ordering", order_err == 0, order_err, 0);
        check("R4 addresses", addr_err == 0, addr_err, 0);
        check("R5 write data", data_err == 0, data_err, 0);
        check("R6 fail timing", fail_err == 0, fail_err, 0);
        check("R6 final fail", test_fail == (corrupt >= 0), test_fail, corrupt >= 0);
        check("R7 done timing", done_err == 0, done_err, 0);
        check("R7 done set", test_done, test_done, 1);

        if (corrupt < 0) begin
            rd_valid = 1'b1; rd_data = 32'h0;
            repeat (2) @(negedge clk);
            rd_valid = 1'b0;
            @(negedge clk);
            check("R7 late read ignored", !test_fail && test_done && !req_valid,
                  {test_fail, test_done, req_valid}, 2);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL R3 watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests + 1, n_fail);
        $finish;
    end

    initial begin
        run(0, -1);
        run(1, -1);
        run(2, -1);
        run(1, 0);
        run(2, N - 1);
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule